// File: doc/BRIEF.md
# Range-Window Address Decoder

This block maps every transaction address on a chip's request path to the identifier of the agent that should serve it. It holds a bank of programmable windows. Each window describes an address range in 1 MiB blocks, a target identifier, an enable and two secure-only controls, one for reads and one for writes. A decode request carries an address, a secure qualifier and a read/write qualifier. One cycle later the block returns the chosen target, a hit flag and a security-violation flag.

When several enabled windows claim the same address, the lowest-numbered window wins. An address that no enabled window claims goes to a default target held in a global register. A transaction that the winning window refuses on security grounds also goes to the default target: hit stays low and the violation flag rises. Window 0 is hardwired at elaboration to cover the internal configuration space. Writes to it are ignored, so no programming sequence can close or move it.

A simple register port programs the bank. Writes take one clock edge. Reads are combinational. The register address is `{global, window[W-1:0], reg[1:0]}`, where reg selects 0 = control, 1 = security, 2 = low block, 3 = high block. When the global bit is set, the global register is selected and the other bits are ignored.

Top module: `addr_window_decoder`

## Requirements
- R1: Bit 0 of a window's control register enables it. A window with bit 0 clear never matches, and its address falls to the next matching window or to the default target.
- R2: On a hit the response target equals the target field of the winning window's control register, bits [7:4] (TID_W = 4).
- R3: The low-block register holds address bits [39:20] in its bits [23:4]. Bits [3:0] and bits [31:24] always read as zero. An address below the window base does not match.
- R4: The high-block register uses the same encoding and is inclusive. An address whose 1 MiB block equals the high block matches. The next block does not match, so the window ends at ((high + 0x10) << 16) - 1.
- R5: An address that no enabled window matches returns the default target held in bits [3:0] of the global register, with hit low and violation low.
- R6: Security register bit 0 is write-secure-only. A non-secure write that wins such a window returns the default target with hit low and violation high. Secure writes and non-secure reads still hit.
- R7: Security register bit 1 is read-secure-only. A non-secure read that wins such a window returns the default target with hit low and violation high. Non-secure writes are not affected by bit 1.
- R8: Window 0 ignores all writes. It reads back its elaboration values: enabled, target 0xE, blocks 0x00F00 to 0x00F0F. It keeps decoding addresses 0xF000_0000 to 0xF0FF_FFFF to target 0xE.
- R9: When enabled windows overlap, the lowest-numbered matching window decides the target and the security check.
- R10: A response appears exactly one clock edge after the request, and the response valid signal follows the request valid signal. A register write takes effect for a request sampled on the following edge, and not for a request sampled on the same edge.
- R11: Each writable register reads back, combinationally, the value last written to its implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address {global, window, reg} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| dec_valid | input | 1 | Decode request valid |
| dec_addr | input | 40 | Physical address to decode |
| dec_secure | input | 1 | Request is secure |
| dec_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_tid | output | 4 | Chosen target identifier |
| rsp_hit | output | 1 | A window claimed the address and allowed the access |
| rsp_viol | output | 1 | The winning window refused the access on security grounds |

## Verification
Addresses are placed one block below, at, and one block past each window edge, which separates a correct inclusive high compare from an exclusive one and a correct base compare from an off-by-one. Overlapping windows are probed both inside the shared region and in the part only the higher-numbered window covers, which separates lowest-first priority from highest-first or last-written. Every combination of secure/non-secure and read/write is sent against each secure-only bit, which shows whether the read and write controls are kept apart. A register write issued together with a decode request, and again one cycle before it, pins down when new settings take effect.

// File: rtl/awd_pkg.sv
package awd_pkg;
   localparam int CFG_DW    = 32;
   localparam int GRAN_LSB  = 20;
   localparam int TID_LSB   = 4;
   localparam int BLK_LSB   = 4;
   localparam int BIT_EN    = 0;
   localparam int BIT_WSEC  = 0;
   localparam int BIT_RSEC  = 1;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_SEC  = 2'd1,
      REG_LO   = 2'd2,
      REG_HI   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/awd_regbank.sv
module awd_regbank
   import awd_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int AW = 40,
   parameter int TID_W = 4,
   parameter logic [TID_W-1:0] WIN0_TID = 'hE,
   parameter logic [AW-GRAN_LSB-1:0] WIN0_LO = 'h00F00,
   parameter logic [AW-GRAN_LSB-1:0] WIN0_HI = 'h00F0F,
   localparam int BW = AW - GRAN_LSB,
   localparam int WIN_W = $clog2(NWIN),
   localparam int CAW = WIN_W + 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_wr,
   input  logic [CAW-1:0]              cfg_addr,
   input  logic [CFG_DW-1:0]           cfg_wdata,
   output logic [CFG_DW-1:0]           cfg_rdata,
   output logic [NWIN-1:0]             win_en,
   output logic [NWIN-1:0]             win_ws,
   output logic [NWIN-1:0]             win_rs,
   output logic [NWIN-1:0][TID_W-1:0]  win_tid,
   output logic [NWIN-1:0][BW-1:0]     win_lo,
   output logic [NWIN-1:0][BW-1:0]     win_hi,
   output logic [TID_W-1:0]            dflt_tid
);
   logic             glob;
   logic [WIN_W-1:0] widx;
   reg_sel_e         rsel;
   logic             widx_ok;

   assign glob    = cfg_addr[CAW-1];
   assign widx    = cfg_addr[CAW-2:2];
   assign rsel    = reg_sel_e'(cfg_addr[1:0]);
   assign widx_ok = (int'(widx) < NWIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dflt_tid <= '0;
      else if (cfg_wr && glob)
         dflt_tid <= cfg_wdata[TID_W-1:0];
   end

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      if (g == 0) begin : g_fixed
         // configuration-space window: hardwired, never writable
         assign win_en[g]  = 1'b1;
         assign win_ws[g]  = 1'b0;
         assign win_rs[g]  = 1'b0;
         assign win_tid[g] = WIN0_TID;
         assign win_lo[g]  = WIN0_LO;
         assign win_hi[g]  = WIN0_HI;
      end else begin : g_prog
         logic hit_w;
         assign hit_w = cfg_wr && !glob && (int'(widx) == g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_en[g]  <= 1'b0;
               win_ws[g]  <= 1'b0;
               win_rs[g]  <= 1'b0;
               win_tid[g] <= '0;
               win_lo[g]  <= '0;
               win_hi[g]  <= '0;
            end else if (hit_w) begin
               case (rsel)
                  REG_CTRL: begin
                     win_en[g]  <= cfg_wdata[BIT_EN];
                     win_tid[g] <= cfg_wdata[TID_LSB +: TID_W];
                  end
                  REG_SEC: begin
                     win_ws[g] <= cfg_wdata[BIT_WSEC];
                     win_rs[g] <= cfg_wdata[BIT_RSEC];
                  end
                  REG_LO:  win_lo[g] <= cfg_wdata[BLK_LSB +: BW];
                  default: win_hi[g] <= cfg_wdata[BLK_LSB +: BW];
               endcase
            end
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (glob) begin
         cfg_rdata[TID_W-1:0] = dflt_tid;
      end else if (widx_ok) begin
         case (rsel)
            REG_CTRL: begin
               cfg_rdata[BIT_EN]            = win_en[widx];
               cfg_rdata[TID_LSB +: TID_W]  = win_tid[widx];
            end
            REG_SEC: begin
               cfg_rdata[BIT_WSEC] = win_ws[widx];
               cfg_rdata[BIT_RSEC] = win_rs[widx];
            end
            REG_LO:  cfg_rdata[BLK_LSB +: BW] = win_lo[widx];
            default: cfg_rdata[BLK_LSB +: BW] = win_hi[widx];
         endcase
      end
   end
endmodule

// File: rtl/awd_match.sv
module awd_match
   import awd_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int AW = 40,
   localparam int BW = AW - GRAN_LSB
) (
   input  logic [AW-1:0]           dec_addr,
   input  logic [NWIN-1:0]         win_en,
   input  logic [NWIN-1:0][BW-1:0] win_lo,
   input  logic [NWIN-1:0][BW-1:0] win_hi,
   output logic [NWIN-1:0]         match
);
   logic [BW-1:0] blk;
   assign blk = dec_addr[AW-1:GRAN_LSB];

   for (genvar g = 0; g < NWIN; g++) begin : g_cmp
      assign match[g] = win_en[g] && (blk >= win_lo[g]) && (blk <= win_hi[g]);
   end
endmodule

// File: rtl/awd_select.sv
module awd_select #(
   parameter int NWIN = 8,
   parameter int TID_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       dec_valid,
   input  logic                       dec_secure,
   input  logic                       dec_write,
   input  logic [NWIN-1:0]            match,
   input  logic [NWIN-1:0]            win_ws,
   input  logic [NWIN-1:0]            win_rs,
   input  logic [NWIN-1:0][TID_W-1:0] win_tid,
   input  logic [TID_W-1:0]           dflt_tid,
   output logic                       rsp_valid,
   output logic [TID_W-1:0]           rsp_tid,
   output logic                       rsp_hit,
   output logic                       rsp_viol
);
   logic [NWIN-1:0]  grant;
   logic [TID_W-1:0] g_tid;
   logic             g_ws, g_rs, any, viol;

   // lowest set bit wins
   assign grant = match & (~match + NWIN'(1));
   assign any   = |match;

   always_comb begin
      g_tid = '0;
      g_ws  = 1'b0;
      g_rs  = 1'b0;
      for (int i = 0; i < NWIN; i++) begin
         if (grant[i]) begin
            g_tid = g_tid | win_tid[i];
            g_ws  = g_ws  | win_ws[i];
            g_rs  = g_rs  | win_rs[i];
         end
      end
   end

   assign viol = any && !dec_secure && (dec_write ? g_ws : g_rs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_tid   <= '0;
         rsp_hit   <= 1'b0;
         rsp_viol  <= 1'b0;
      end else begin
         rsp_valid <= dec_valid;
         rsp_tid   <= (any && !viol) ? g_tid : dflt_tid;
         rsp_hit   <= dec_valid && any && !viol;
         rsp_viol  <= dec_valid && viol;
      end
   end

   p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_hit_needs_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> $past(|match));
   p_miss_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_tid == $past(dflt_tid)));
   p_viol_nonsecure_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_viol |-> !$past(dec_secure));
   p_hit_excl_viol_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_viol));
   p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> rsp_valid);
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int AW = 40,
   parameter int TID_W = 4,
   parameter logic [TID_W-1:0] WIN0_TID = 'hE,
   parameter logic [AW-GRAN_LSB-1:0] WIN0_LO = 'h00F00,
   parameter logic [AW-GRAN_LSB-1:0] WIN0_HI = 'h00F0F,
   localparam int BW = AW - GRAN_LSB,
   localparam int CAW = $clog2(NWIN) + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CAW-1:0]    cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata,
   input  logic              dec_valid,
   input  logic [AW-1:0]     dec_addr,
   input  logic              dec_secure,
   input  logic              dec_write,
   output logic              rsp_valid,
   output logic [TID_W-1:0]  rsp_tid,
   output logic              rsp_hit,
   output logic              rsp_viol
);
   if (NWIN < 2 || NWIN > 64) begin : g_bad_nwin
      $error("NWIN must be 2..64");
   end
   if (AW <= GRAN_LSB || BW + BLK_LSB > CFG_DW) begin : g_bad_aw
      $error("AW must be 21..48");
   end
   if (TID_W < 1 || TID_W + TID_LSB > CFG_DW) begin : g_bad_tid
      $error("TID_W out of range");
   end

   logic [NWIN-1:0]            win_en, win_ws, win_rs, match;
   logic [NWIN-1:0][TID_W-1:0] win_tid;
   logic [NWIN-1:0][BW-1:0]    win_lo, win_hi;
   logic [TID_W-1:0]           dflt_tid;

   awd_regbank #(
      .NWIN(NWIN), .AW(AW), .TID_W(TID_W),
      .WIN0_TID(WIN0_TID), .WIN0_LO(WIN0_LO), .WIN0_HI(WIN0_HI)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .win_en(win_en), .win_ws(win_ws), .win_rs(win_rs), .win_tid(win_tid),
      .win_lo(win_lo), .win_hi(win_hi), .dflt_tid(dflt_tid)
   );

   awd_match #(.NWIN(NWIN), .AW(AW)) u_match (
      .dec_addr(dec_addr), .win_en(win_en), .win_lo(win_lo),
      .win_hi(win_hi), .match(match)
   );

   awd_select #(.NWIN(NWIN), .TID_W(TID_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
      .dec_secure(dec_secure), .dec_write(dec_write), .match(match),
      .win_ws(win_ws), .win_rs(win_rs), .win_tid(win_tid),
      .dflt_tid(dflt_tid), .rsp_valid(rsp_valid), .rsp_tid(rsp_tid),
      .rsp_hit(rsp_hit), .rsp_viol(rsp_viol)
   );
endmodule

// File: tb/addr_window_decoder_test.sv
module addr_window_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        dec_valid = 1'b0;
   logic [39:0] dec_addr = '0;
   logic        dec_secure = 1'b0;
   logic        dec_write = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_viol;
   logic [3:0]  rsp_tid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [5:0] GLOB = 6'b100000;
   localparam bit RD = 1'b0, WR = 1'b1, NS = 1'b0, SEC = 1'b1;

   always #5 clk = ~clk;

   addr_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_valid(dec_valid),
      .dec_addr(dec_addr), .dec_secure(dec_secure), .dec_write(dec_write),
      .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_hit(rsp_hit),
      .rsp_viol(rsp_viol)
   );

   function automatic logic [5:0] ra(input int w, input int s);
      return {1'b0, 3'(w), 2'(s)};
   endfunction

   task automatic check(input string rq, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string rq, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk);
      cfg_addr = a; #1;
      check(rq, {8'h0, cfg_rdata}, {8'h0, exp});
   endtask

   // response word: {valid, tid, hit, viol}
   task automatic dec_chk(input string rq, input logic [39:0] a, input bit sec,
                          input bit wr, input logic [3:0] tid, input bit hit, input bit viol);
      @(negedge clk);
      dec_valid = 1'b1; dec_addr = a; dec_secure = sec; dec_write = wr;
      @(posedge clk); #1;
      dec_valid = 1'b0;
      check(rq, {33'h0, rsp_valid, rsp_tid, rsp_hit, rsp_viol},
                {33'h0, 1'b1, tid, hit, viol});
   endtask

   task automatic t_reset;
      check("R10 reset valid", {39'h0, rsp_valid}, 40'h0);
      rd_chk("R5 reset default", GLOB, 32'h0);
      rd_chk("R1 reset win1 ctrl", ra(1, 0), 32'h0);
      dec_chk("R5 reset miss", 40'h00_1000_0000, SEC, RD, 4'h0, 1'b0, 1'b0);
   endtask

   task automatic t_program;
      wr_reg(GLOB, 32'hA);
      wr_reg(ra(1, 2), 32'h0000_100F);
      wr_reg(ra(1, 3), 32'hFF00_1FF0);
      wr_reg(ra(1, 0), 32'h0000_0051);
      rd_chk("R3 low readback drops bits 3:0", ra(1, 2), 32'h0000_1000);
      rd_chk("R11 high readback", ra(1, 3), 32'h0000_1FF0);
      rd_chk("R11 ctrl readback", ra(1, 0), 32'h0000_0051);
      rd_chk("R5 default readback", GLOB, 32'hA);
   endtask

   task automatic t_edges;
      dec_chk("R2 hit target", 40'h00_1234_5678, NS, RD, 4'h5, 1'b1, 1'b0);
      dec_chk("R3 base block hits", 40'h00_1000_0000, NS, RD, 4'h5, 1'b1, 1'b0);
      dec_chk("R3 below base misses", 40'h00_0FFF_FFFF, NS, RD, 4'hA, 1'b0, 1'b0);
      dec_chk("R4 last byte of high block", 40'h00_1FFF_FFFF, NS, WR, 4'h5, 1'b1, 1'b0);
      dec_chk("R4 block after high misses", 40'h00_2000_0000, NS, WR, 4'hA, 1'b0, 1'b0);
      dec_chk("R5 far miss", 40'hFF_0000_0000, SEC, WR, 4'hA, 1'b0, 1'b0);
   endtask

   task automatic t_enable;
      wr_reg(ra(1, 0), 32'h0000_0050);
      dec_chk("R1 disabled window misses", 40'h00_1800_0000, NS, RD, 4'hA, 1'b0, 1'b0);
      wr_reg(ra(1, 0), 32'h0000_0051);
      dec_chk("R1 re-enabled hits", 40'h00_1800_0000, NS, RD, 4'h5, 1'b1, 1'b0);
   endtask

   task automatic t_priority;
      wr_reg(ra(2, 2), 32'h0000_1800);
      wr_reg(ra(2, 3), 32'h0000_2FF0);
      wr_reg(ra(2, 0), 32'h0000_0061);
      dec_chk("R9 overlap lowest wins", 40'h00_1800_0000, NS, RD, 4'h5, 1'b1, 1'b0);
      dec_chk("R9 higher window alone", 40'h00_2800_0000, NS, RD, 4'h6, 1'b1, 1'b0);
      wr_reg(ra(1, 0), 32'h0000_0050);
      dec_chk("R1 disabled lower yields to higher", 40'h00_1800_0000, NS, RD, 4'h6, 1'b1, 1'b0);
      wr_reg(ra(1, 0), 32'h0000_0051);
      wr_reg(ra(2, 1), 32'h1);
      dec_chk("R9 security of lower winner only", 40'h00_1800_0000, NS, WR, 4'h5, 1'b1, 1'b0);
      wr_reg(ra(2, 1), 32'h0);
   endtask

   task automatic t_security;
      wr_reg(ra(1, 1), 32'h1);
      rd_chk("R11 sec readback", ra(1, 1), 32'h1);
      dec_chk("R6 non-secure write refused", 40'h00_1000_0000, NS, WR, 4'hA, 1'b0, 1'b1);
      dec_chk("R6 secure write hits", 40'h00_1000_0000, SEC, WR, 4'h5, 1'b1, 1'b0);
      dec_chk("R6 non-secure read hits", 40'h00_1000_0000, NS, RD, 4'h5, 1'b1, 1'b0);
      wr_reg(ra(1, 1), 32'h2);
      dec_chk("R7 non-secure read refused", 40'h00_1000_0000, NS, RD, 4'hA, 1'b0, 1'b1);
      dec_chk("R7 secure read hits", 40'h00_1000_0000, SEC, RD, 4'h5, 1'b1, 1'b0);
      dec_chk("R7 non-secure write unaffected", 40'h00_1000_0000, NS, WR, 4'h5, 1'b1, 1'b0);
      wr_reg(ra(1, 1), 32'h0);
   endtask

   task automatic t_win0;
      rd_chk("R8 win0 ctrl", ra(0, 0), 32'h0000_00E1);
      wr_reg(ra(0, 0), 32'h0000_0030);
      wr_reg(ra(0, 2), 32'h0000_0000);
      wr_reg(ra(0, 1), 32'h3);
      rd_chk("R8 win0 ctrl after write", ra(0, 0), 32'h0000_00E1);
      rd_chk("R8 win0 low after write", ra(0, 2), 32'h0000_F000);
      rd_chk("R8 win0 high", ra(0, 3), 32'h0000_F0F0);
      rd_chk("R8 win0 sec after write", ra(0, 1), 32'h0);
      dec_chk("R8 win0 still decodes", 40'h00_F000_0000, NS, WR, 4'hE, 1'b1, 1'b0);
      dec_chk("R8 win0 top byte", 40'h00_F0FF_FFFF, NS, RD, 4'hE, 1'b1, 1'b0);
   endtask

   task automatic t_timing;
      // write and request on the same edge: old default; next edge: new
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = GLOB; cfg_wdata = 32'h3;
      dec_valid = 1'b1; dec_addr = 40'h00_5000_0000; dec_secure = 1'b0; dec_write = 1'b0;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
      check("R10 same-edge write not seen", {36'h0, rsp_tid}, 40'hA);
      check("R10 response one edge later", {39'h0, rsp_valid}, 40'h1);
      @(posedge clk); #1;
      dec_valid = 1'b0;
      check("R10 write seen by next request", {36'h0, rsp_tid}, 40'h3);
      @(posedge clk); #1;
      check("R10 valid follows request", {39'h0, rsp_valid}, 40'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_program;
      t_edges;
      t_enable;
      t_priority;
      t_security;
      t_win0;
      t_timing;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule